// File: doc/BRIEF.md
# Burst Column Address Generator

This block produces the column address sequence of one burst for a two-bank synchronous graphics memory. A column command loads it with a start column, a three-bit burst length code and an order select (sequential or interleaved). From the next clock it presents one column per beat, moving on to the next beat on every clock edge where `enable` is high. It marks each beat with `valid` and the final beat of a fixed-length burst with `last`.

A burst ends in one of three ways. A fixed-length burst runs to its end. A full-page burst (256 columns) wraps around and runs until a stop request arrives. A new column command replaces whatever burst is in progress, and one may arrive on every clock. An interleaved full-page request and a reserved length code both raise a one-cycle configuration error.

The controller is a three-state machine:
- `ST_IDLE`: no burst.
- `ST_FIXED`: a burst of 1, 2, 4 or 8 beats.
- `ST_PAGE`: a full-page burst.

Its transitions are:
- load-fixed: any state to `ST_FIXED`, on an accepted command with a fixed length.
- load-page: any state to `ST_PAGE`, on an accepted command with the full-page code.
- finish: `ST_FIXED` to `ST_IDLE`, when `enable` is high on the last beat.
- stop: `ST_PAGE` to `ST_IDLE`, on `stop_req`.

Top module: `burst_col_gen`

## Requirements
- R1: While reset is active and on the first cycle after it, `valid`, `last` and `cfg_err` are low.
- R2: The length codes are 000 = 1 beat, 001 = 2, 010 = 4, 011 = 8 and 111 = full page. A command with code 100, 101 or 110 is not accepted: the state and the column stay as they were, and `cfg_err` is high for the one cycle after that command.
- R3: An accepted command presents `start_col` as beat 0 with `valid` high on the next cycle. It replaces any burst in progress and takes priority over `stop_req` and over beat advance.
- R4: Sequential order: beat k is the start column with its low log2(length) bits replaced by (start + k) modulo the length. Length 4 from 0x41 gives 0x41, 0x42, 0x43, 0x40.
- R5: Interleaved order (`interleave` = 1): beat k is the start column XOR k. Length 8 from 0xA5 gives A5, A4, A7, A6, A1, A0, A3, A2.
- R6: During a fixed-length burst, the column bits above the length field keep the values of the start column.
- R7: The burst moves one beat per clock edge with `enable` high. With `enable` low, the column and `valid` hold.
- R8: `last` is high only on the final beat of a fixed-length burst. `valid` drops on the cycle after that beat is consumed with `enable` high.
- R9: A full-page command with `interleave` high raises `cfg_err` for one cycle and runs in sequential order.
- R10: A full-page burst counts upward from column 255 to 0 and continues. It never raises `last`.
- R11: `stop_req` ends a full-page burst on the next clock. During a fixed-length burst it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | New column command |
| start_col | input | COL_W | Start column of the command |
| len_code | input | 3 | Burst length code |
| interleave | input | 1 | 1 = interleaved order, 0 = sequential |
| enable | input | 1 | Advance to the next beat at this edge |
| stop_req | input | 1 | Burst stop request |
| col | output | COL_W | Current column |
| valid | output | 1 | A beat is being presented |
| last | output | 1 | Final beat of a fixed-length burst |
| cfg_err | output | 1 | Previous command was reserved or an interleaved full page |

## Verification
The bound checker checks the following on every cycle:
- `last` implies `valid`.
- Consuming the last beat drops `valid`.
- An idle block stays idle without a command.
- Holding `enable` low freezes the column.
- A single-beat command loads the start column with `last` set.
- A reserved code leaves an idle block idle.
- An interleaved full-page command raises `cfg_err`.

Only the directed scenarios can show the following:
- The actual beat orders, both sequential wrap and XOR order.
- Preservation of the upper column bits.
- The wrap from 255 to 0.
- That a stop request is ignored in fixed bursts but honoured in full-page bursts.
- Replacement of a burst by a new command.

// File: rtl/bcg_pkg.sv
package bcg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FIXED = 2'd1,
        ST_PAGE  = 2'd2
    } bcg_state_e;

    typedef enum logic {
        ORD_SEQ = 1'b0,
        ORD_ILV = 1'b1
    } bcg_order_e;

    localparam logic [2:0] LEN_CODE_FULL  = 3'b111;
    localparam logic [2:0] LEN_CODE_MAXFX = 3'b011;
    localparam int         FIXED_LOG2_MAX = 3;

endpackage

// File: rtl/bcg_len_decode.sv
module bcg_len_decode
    import bcg_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic [2:0]       len_code,
    output logic [COL_W-1:0] beat_mask,
    output logic             is_full,
    output logic             is_rsvd
);

    // beat_mask = burst length - 1; all ones for a full page
    always_comb begin
        beat_mask = '0;
        is_full   = 1'b0;
        is_rsvd   = 1'b0;
        if (len_code == LEN_CODE_FULL) begin
            is_full   = 1'b1;
            beat_mask = '1;
        end else if (len_code <= LEN_CODE_MAXFX) begin
            for (int b = 0; b < FIXED_LOG2_MAX; b++) begin
                if (3'(b) < len_code) begin
                    beat_mask[b] = 1'b1;
                end
            end
        end else begin
            is_rsvd = 1'b1;
        end
    end

endmodule

// File: rtl/bcg_addr_step.sv
module bcg_addr_step
    import bcg_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic [COL_W-1:0] base_col,
    input  logic [COL_W-1:0] beat_cnt,
    input  logic [COL_W-1:0] beat_mask,
    input  bcg_order_e       order,
    output logic [COL_W-1:0] col
);

    logic [COL_W-1:0] seq_sum;

    assign seq_sum = base_col + beat_cnt;

    // per bit: masked bits follow the wrapped sum or the XOR, the rest keep the base
    for (genvar i = 0; i < COL_W; i++) begin : g_bit
        assign col[i] = (order == ORD_ILV) ? (base_col[i] ^ beat_cnt[i])
                                           : (beat_mask[i] ? seq_sum[i] : base_col[i]);
    end

endmodule

// File: rtl/bcg_ctrl.sv
module bcg_ctrl
    import bcg_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [COL_W-1:0] start_col,
    input  logic             interleave,
    input  logic             enable,
    input  logic             stop_req,
    input  logic [COL_W-1:0] dec_mask,
    input  logic             dec_full,
    input  logic             dec_rsvd,
    output logic [COL_W-1:0] base_q,
    output logic [COL_W-1:0] beat_q,
    output logic [COL_W-1:0] mask_q,
    output bcg_order_e       order_q,
    output logic             valid,
    output logic             last,
    output logic             cfg_err
);

    bcg_state_e state_q, state_d;
    logic       accept;
    logic       at_last;

    assign accept  = start && !dec_rsvd;
    assign at_last = (beat_q == mask_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) state_d = dec_full ? ST_PAGE : ST_FIXED;
            end
            ST_FIXED: begin
                if (accept)                 state_d = dec_full ? ST_PAGE : ST_FIXED;
                else if (enable && at_last) state_d = ST_IDLE;
            end
            ST_PAGE: begin
                if (accept)        state_d = dec_full ? ST_PAGE : ST_FIXED;
                else if (stop_req) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            beat_q  <= '0;
            mask_q  <= '0;
            order_q <= ORD_SEQ;
            cfg_err <= 1'b0;
        end else begin
            cfg_err <= start && (dec_rsvd || (dec_full && interleave));
            if (accept) begin
                base_q  <= start_col;
                beat_q  <= '0;
                mask_q  <= dec_mask;
                order_q <= (interleave && !dec_full) ? ORD_ILV : ORD_SEQ;
            end else if (state_q != ST_IDLE && enable) begin
                beat_q  <= beat_q + 1'b1;
            end
        end
    end

    always_comb begin
        valid = (state_q != ST_IDLE);
        last  = (state_q == ST_FIXED) && at_last;
    end

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
    import bcg_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [COL_W-1:0] start_col,
    input  logic [2:0]       len_code,
    input  logic             interleave,
    input  logic             enable,
    input  logic             stop_req,
    output logic [COL_W-1:0] col,
    output logic             valid,
    output logic             last,
    output logic             cfg_err
);

    logic [COL_W-1:0] dec_mask;
    logic             dec_full;
    logic             dec_rsvd;
    logic [COL_W-1:0] base_q;
    logic [COL_W-1:0] beat_q;
    logic [COL_W-1:0] mask_q;
    bcg_order_e       order_q;

    bcg_len_decode #(.COL_W(COL_W)) u_dec (
        .len_code  (len_code),
        .beat_mask (dec_mask),
        .is_full   (dec_full),
        .is_rsvd   (dec_rsvd)
    );

    bcg_ctrl #(.COL_W(COL_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_col  (start_col),
        .interleave (interleave),
        .enable     (enable),
        .stop_req   (stop_req),
        .dec_mask   (dec_mask),
        .dec_full   (dec_full),
        .dec_rsvd   (dec_rsvd),
        .base_q     (base_q),
        .beat_q     (beat_q),
        .mask_q     (mask_q),
        .order_q    (order_q),
        .valid      (valid),
        .last       (last),
        .cfg_err    (cfg_err)
    );

    bcg_addr_step #(.COL_W(COL_W)) u_step (
        .base_col  (base_q),
        .beat_cnt  (beat_q),
        .beat_mask (mask_q),
        .order     (order_q),
        .col       (col)
    );

endmodule

// File: rtl/bcg_checker.sv
module bcg_checker #(
    parameter int COL_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [COL_W-1:0] start_col,
    input logic [2:0]       len_code,
    input logic             interleave,
    input logic             enable,
    input logic             stop_req,
    input logic [COL_W-1:0] col,
    input logic             valid,
    input logic             last,
    input logic             cfg_err
);

    assert_last_in_burst_R8: assert property (@(posedge clk) disable iff (!rst_n)
        last |-> valid);

    assert_valid_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && last && enable && !start) |=> !valid);

    assert_idle_stays_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid && !start) |=> !valid);

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !enable && !start && !stop_req) |=> (valid && $stable(col)));

    assert_single_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (start && len_code == 3'b000) |=> (valid && last && col == $past(start_col)));

    assert_rsvd_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !valid && (len_code == 3'b100 || len_code == 3'b101 || len_code == 3'b110))
        |=> (!valid && cfg_err));

    assert_page_ilv_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && len_code == 3'b111 && interleave) |=> cfg_err);

endmodule

bind burst_col_gen bcg_checker #(.COL_W(COL_W)) u_bcg_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .start_col  (start_col),
    .len_code   (len_code),
    .interleave (interleave),
    .enable     (enable),
    .stop_req   (stop_req),
    .col        (col),
    .valid      (valid),
    .last       (last),
    .cfg_err    (cfg_err)
);

// File: tb/test_burst_col_gen.sv
module test_burst_col_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] start_col = '0;
    logic [2:0] len_code = '0;
    logic       interleave = 1'b0;
    logic       enable = 1'b0;
    logic       stop_req = 1'b0;
    logic [7:0] col;
    logic       valid;
    logic       last;
    logic       cfg_err;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    burst_col_gen #(.COL_W(8)) i_burst_col_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_col  (start_col),
        .len_code   (len_code),
        .interleave (interleave),
        .enable     (enable),
        .stop_req   (stop_req),
        .col        (col),
        .valid      (valid),
        .last       (last),
        .cfg_err    (cfg_err)
    );

    task automatic chk(string req, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_col(logic [7:0] base, int k, logic [2:0] code, logic ilv);
        int len;
        logic [7:0] m;
        len = (code == 3'b111) ? 256 : (1 << code);
        m = 8'(len - 1);
        if (ilv && code != 3'b111) return base ^ 8'(k);
        return (base & ~m) | ((base + 8'(k)) & m);
    endfunction

    task automatic issue(logic [7:0] c, logic [2:0] code, logic ilv);
        start = 1'b1; start_col = c; len_code = code; interleave = ilv;
    endtask

    task automatic t_reset();
        chk("R1", "valid in reset", int'(valid), 0);
        chk("R1", "last in reset", int'(last), 0);
        chk("R1", "cfg_err in reset", int'(cfg_err), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "valid after reset", int'(valid), 0);
        chk("R1", "cfg_err after reset", int'(cfg_err), 0);
    endtask

    // runs a whole fixed burst with enable high, optional stop_req held (R11)
    task automatic run_fixed(string req, logic [7:0] base, logic [2:0] code, logic ilv, logic stp);
        int n;
        n = 1 << code;
        enable = 1'b1;
        issue(base, code, ilv);
        @(negedge clk);
        start = 1'b0;
        stop_req = stp;
        for (int k = 0; k < n; k++) begin
            chk(req, "col", int'(col), int'(exp_col(base, k, code, ilv)));
            chk(req, "valid", int'(valid), 1);
            chk("R8", "last", int'(last), (k == n - 1) ? 1 : 0);
            @(negedge clk);
        end
        chk("R8", "valid after last beat", int'(valid), 0);
        stop_req = 1'b0;
    endtask

    task automatic t_seq_example();
        logic [7:0] e [4] = '{8'h41, 8'h42, 8'h43, 8'h40};
        enable = 1'b1;
        issue(8'h41, 3'b010, 1'b0);
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 4; k++) begin
            chk("R4", "seq col", int'(col), int'(e[k]));
            chk("R6", "upper bits", int'(col[7:2]), int'(6'h10));
            @(negedge clk);
        end
        chk("R8", "valid low", int'(valid), 0);
    endtask

    task automatic t_ilv_example();
        logic [7:0] e [8] = '{8'hA5, 8'hA4, 8'hA7, 8'hA6, 8'hA1, 8'hA0, 8'hA3, 8'hA2};
        enable = 1'b1;
        issue(8'hA5, 3'b011, 1'b1);
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 8; k++) begin
            chk("R5", "ilv col", int'(col), int'(e[k]));
            chk("R6", "upper bits", int'(col[7:3]), int'(5'h14));
            @(negedge clk);
        end
        chk("R8", "valid low", int'(valid), 0);
    endtask

    task automatic t_hold();
        enable = 1'b0;
        issue(8'h10, 3'b011, 1'b0);
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 3; k++) begin
            chk("R7", "held col", int'(col), 8'h10);
            chk("R7", "held valid", int'(valid), 1);
            @(negedge clk);
        end
        enable = 1'b1;
        chk("R7", "col before step", int'(col), 8'h10);
        @(negedge clk);
        chk("R7", "col after step", int'(col), 8'h11);
        stop_req = 1'b1;
        @(negedge clk);
        chk("R11", "stop ignored fixed", int'(valid), 1);
        chk("R11", "stop ignored col", int'(col), 8'h12);
        stop_req = 1'b0;
        issue(8'h00, 3'b000, 1'b0);
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        chk("R8", "len1 then idle", int'(valid), 0);
    endtask

    task automatic t_page();
        enable = 1'b1;
        issue(8'hFC, 3'b111, 1'b0);
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 6; k++) begin
            chk("R10", "page col", int'(col), int'(8'(8'hFC + k)));
            chk("R10", "page no last", int'(last), 0);
            chk("R10", "page valid", int'(valid), 1);
            @(negedge clk);
        end
        stop_req = 1'b1;
        @(negedge clk);
        stop_req = 1'b0;
        chk("R11", "stop ends page", int'(valid), 0);
        chk("R11", "no last after stop", int'(last), 0);
    endtask

    task automatic t_page_ilv();
        enable = 1'b1;
        issue(8'hFE, 3'b111, 1'b1);
        @(negedge clk);
        start = 1'b0;
        chk("R9", "cfg_err raised", int'(cfg_err), 1);
        chk("R9", "col beat0", int'(col), 8'hFE);
        @(negedge clk);
        chk("R9", "cfg_err one cycle", int'(cfg_err), 0);
        chk("R9", "seq fallback beat1", int'(col), 8'hFF);
        @(negedge clk);
        chk("R9", "seq fallback beat2", int'(col), 8'h00);
        stop_req = 1'b1;
        @(negedge clk);
        stop_req = 1'b0;
        chk("R11", "stop ends page", int'(valid), 0);
    endtask

    task automatic t_reserved();
        enable = 1'b1;
        issue(8'h99, 3'b101, 1'b0);
        @(negedge clk);
        start = 1'b0;
        chk("R2", "rsvd not started", int'(valid), 0);
        chk("R2", "rsvd cfg_err", int'(cfg_err), 1);
        @(negedge clk);
        chk("R2", "cfg_err cleared", int'(cfg_err), 0);
        issue(8'h60, 3'b011, 1'b0);
        @(negedge clk);
        chk("R3", "burst loaded", int'(col), 8'h60);
        issue(8'h99, 3'b110, 1'b0);
        @(negedge clk);
        start = 1'b0;
        chk("R2", "rsvd ignored mid-burst col", int'(col), 8'h61);
        chk("R2", "rsvd ignored mid-burst valid", int'(valid), 1);
        chk("R2", "rsvd mid-burst cfg_err", int'(cfg_err), 1);
        issue(8'h00, 3'b000, 1'b0);
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_override();
        enable = 1'b1;
        issue(8'h20, 3'b011, 1'b0);
        @(negedge clk);
        start = 1'b0;
        chk("R3", "first burst b0", int'(col), 8'h20);
        @(negedge clk);
        chk("R3", "first burst b1", int'(col), 8'h21);
        issue(8'h80, 3'b010, 1'b1);
        stop_req = 1'b1;
        @(negedge clk);
        start = 1'b0;
        stop_req = 1'b0;
        chk("R3", "override col", int'(col), 8'h80);
        chk("R3", "override valid", int'(valid), 1);
        for (int k = 1; k < 4; k++) begin
            @(negedge clk);
            chk("R5", "override ilv", int'(col), int'(8'h80 ^ 8'(k)));
        end
        chk("R8", "override last", int'(last), 1);
        for (int k = 0; k < 3; k++) begin
            issue(8'(8'h30 + 8'h10 * k), 3'b011, 1'b0);
            @(negedge clk);
            chk("R3", "back to back load", int'(col), int'(8'(8'h30 + 8'h10 * k)));
        end
        start = 1'b0;
        issue(8'h00, 3'b000, 1'b0);
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(2_000_000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_seq_example();
        t_ilv_example();
        run_fixed("R4", 8'h37, 3'b001, 1'b0, 1'b0);
        run_fixed("R3", 8'h37, 3'b000, 1'b0, 1'b0);
        run_fixed("R4", 8'hCD, 3'b011, 1'b0, 1'b1);
        run_fixed("R5", 8'h5E, 3'b010, 1'b1, 1'b1);
        t_hold();
        t_page();
        t_page_ilv();
        t_reserved();
        t_override();
        finish_run();
    end

endmodule